// File: doc/BRIEF.md
# Display Interrupt Status Controller

This block gathers single-cycle event pulses from a display engine, such as the start and the end of a frame, into one 32-bit interrupt register. It raises a single level-sensitive interrupt line toward the processor. The low byte of the register holds sticky status flags, one per event source. The byte above it holds an enable for each flag, placed eight positions above the flag it gates. The remaining upper bits are general control storage that reads back exactly as written.

Software reads the whole register over a simple read/write port. To acknowledge one event, it writes back the upper 24 bits exactly as read, with ones in every status position except the one to clear. A zero written to a status bit clears that flag, and a one leaves it as it was. An event that arrives in the same cycle as its own acknowledge wins, so no event is lost. Writing zero to the whole register clears every flag and disables every source.

Top module: `dint_ctrl`

## Requirements
- R1: After a synchronous reset, the register reads all zeros and `irq_o` is low.
- R2: A pulse on `evt_i[k]` sets status bit k, which is visible on `rd_data_o[k]` in the cycle after the pulse. The flag stays set until software clears it.
- R3: A status flag sets whether or not its enable bit is set.
- R4: A write loads `wr_data_i[31:8]` into register bits 31..8 (enables and control). Without a write, those bits hold their value.
- R5: On a write, a 0 in status bit k clears that flag. A 1 leaves it unchanged and never sets a clear flag.
- R6: If an event pulse on bit k coincides with a write that clears bit k, the flag ends up set.
- R7: `irq_o` is high exactly when some status bit k and its enable bit k+8 are both set. The frame-end flag is bit 1, gated by bit 9. The frame-start flag is bit 2, gated by bit 10.
- R8: Writing all zeros, with no event in that cycle, clears every status flag and every enable, and `irq_o` goes low.
- R9: A write of the upper 24 bits as read, with low byte 0xFF with bit k inverted, clears only flag k and keeps every other bit of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Event pulses; bit k sets status flag k |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Current register contents |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions check several rules on every cycle. Each flag sets after its pulse, holds without a clearing write, and clears after a zero is written with no competing event. The upper bits take written data and otherwise stay still. The interrupt rises only after an event or a write, and a zero write with no event empties the register. Only the bench's scenarios can show the rest. These are the exact pairing of each enable with its flag across all eight sources, the full sweep of 256 clear masks against mixed enables, the read-modify-write acknowledge sequence, and the collision of an event with its own clear on every bit.

// File: rtl/dint_pkg.sv
package dint_pkg;

    localparam int DINT_REG_W  = 32;
    localparam int DINT_STAT_W = 8;

    // flag positions the display engine drives
    typedef enum int {
        EV_FRAME_END   = 1,
        EV_FRAME_START = 2
    } dint_evt_e;

    // per-flag write command
    typedef struct packed {
        logic wr;    // a register write happens this cycle
        logic keep;  // written status bit value (1 keeps, 0 clears)
    } bit_cmd_t;

    // next value of one sticky flag; an event wins over a clear
    function automatic logic flag_next(logic cur, logic evt, bit_cmd_t c);
        return evt | (cur & (~c.wr | c.keep));
    endfunction

endpackage

// File: rtl/dint_status_bank.sv
module dint_status_bank
    import dint_pkg::*;
#(
    parameter int STAT_W = DINT_STAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] evt,
    input  logic              wr,
    input  logic [STAT_W-1:0] keep,
    output logic [STAT_W-1:0] status
);

    for (genvar k = 0; k < STAT_W; k++) begin : g_flag
        bit_cmd_t cmd;
        logic     flag_q;

        assign cmd.wr   = wr;
        assign cmd.keep = keep[k];

        always_ff @(posedge clk) begin
            if (rst) flag_q <= 1'b0;
            else     flag_q <= flag_next(flag_q, evt[k], cmd);
        end

        assign status[k] = flag_q;

        assert_set_R2: assert property (@(posedge clk) disable iff (rst)
            evt[k] |=> flag_q);
        assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
            (flag_q && !(wr && !keep[k])) |=> flag_q);
        assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
            (wr && !keep[k] && !evt[k]) |=> !flag_q);
        assert_no_spurious_set_R5: assert property (@(posedge clk) disable iff (rst)
            (!flag_q && !evt[k]) |=> !flag_q);
    end

endmodule

// File: rtl/dint_upper_reg.sv
module dint_upper_reg #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (wr) q <= wdata;
    end

    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        wr |=> (q == $past(wdata)));
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(q));

endmodule

// File: rtl/dint_irq_gate.sv
module dint_irq_gate #(
    parameter int STAT_W = 8
) (
    input  logic [STAT_W-1:0] status,
    input  logic [STAT_W-1:0] enable,
    output logic              irq
);

    logic [STAT_W-1:0] pend;

    for (genvar k = 0; k < STAT_W; k++) begin : g_pend
        assign pend[k] = status[k] & enable[k];
    end

    assign irq = |pend;

endmodule

// File: rtl/dint_ctrl.sv
module dint_ctrl
    import dint_pkg::*;
#(
    parameter int REG_W  = DINT_REG_W,
    parameter int STAT_W = DINT_STAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] evt_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              irq_o
);

    localparam int UP_W = REG_W - STAT_W;

    logic [STAT_W-1:0] status;
    logic [UP_W-1:0]   upper_q;

    dint_status_bank #(.STAT_W(STAT_W)) u_status (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_i),
        .wr     (wr_en_i),
        .keep   (wr_data_i[STAT_W-1:0]),
        .status (status)
    );

    dint_upper_reg #(.W(UP_W)) u_upper (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_en_i),
        .wdata (wr_data_i[REG_W-1:STAT_W]),
        .q     (upper_q)
    );

    dint_irq_gate #(.STAT_W(STAT_W)) u_gate (
        .status (status),
        .enable (upper_q[STAT_W-1:0]),
        .irq    (irq_o)
    );

    assign rd_data_o = {upper_q, status};

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(wr_en_i || (evt_i != '0)));
    assert_zero_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_data_i == '0 && evt_i == '0) |=> (rd_data_o == '0 && !irq_o));

endmodule

// File: tb/tb_dint_ctrl.sv
module tb_dint_ctrl;
    import dint_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  evt = '0;
    logic        wr  = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rd;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dint_ctrl dut (
        .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr),
        .wr_data_i(wdata), .rd_data_o(rd), .irq_o(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive for one clock edge, then sample at the following falling edge
    task automatic step(logic [7:0] e, logic w, logic [31:0] d);
        evt = e; wr = w; wdata = d;
        @(posedge clk);
        @(negedge clk);
        evt = '0; wr = 1'b0; wdata = '0;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] up;
        logic [7:0]  en;
        @(negedge clk);
        step(8'h00, 1'b0, 32'h0);
        rst = 1'b0;
        chk("R1 reset reg", rd, 32'h0);
        chk("R1 reset irq", {31'h0, irq}, 32'h0);

        // per-source sweep with enable on and off
        for (int k = 0; k < 8; k++) begin
            for (int e = 0; e < 2; e++) begin
                up = (e != 0) ? (32'h1 << (k + 8)) : 32'h0;
                step(8'h00, 1'b1, up | 32'hFF);
                chk("R5 write one does not set", rd, up);
                step(8'h01 << k, 1'b0, 32'h0);
                chk("R2 R3 flag set", rd, up | (32'h1 << k));
                chk("R7 irq follows enable", {31'h0, irq}, e);
                step(8'h00, 1'b0, 32'h0);
                chk("R2 sticky", rd, up | (32'h1 << k));
                step(8'h00, 1'b1, {rd[31:8], 8'hFF ^ (8'h01 << k)});
                chk("R9 ack clears flag", rd, up);
                chk("R9 irq drops", {31'h0, irq}, 32'h0);
            end
        end

        // named sources: frame end gated by bit 9, frame start by bit 10
        step(8'h00, 1'b1, 32'h0000_02FF);
        step(8'h01 << EV_FRAME_START, 1'b0, 32'h0);
        chk("R7 frame start not gated by bit 9", {31'h0, irq}, 32'h0);
        step(8'h00, 1'b1, 32'h0000_06FF);
        chk("R7 frame start enabled bit 10", {31'h0, irq}, 32'h1);
        step(8'h00, 1'b1, 32'h0000_02FF);
        chk("R7 frame start disabled again", {31'h0, irq}, 32'h0);
        step(8'h01 << EV_FRAME_END, 1'b0, 32'h0);
        chk("R7 frame end irq", {31'h0, irq}, 32'h1);
        chk("R9 both flags held", rd, 32'h0000_0206);
        step(8'h00, 1'b1, {rd[31:8], 8'hFD});
        chk("R9 ack frame end only", rd, 32'h0000_0204);
        chk("R7 irq low after ack", {31'h0, irq}, 32'h0);

        // event colliding with its own clear
        for (int k = 0; k < 8; k++) begin
            step(8'h01 << k, 1'b0, 32'h0);
            step(8'h01 << k, 1'b1, 32'h0000_0000);
            chk("R6 event wins over clear", rd, 32'h1 << k);
            step(8'h00, 1'b1, 32'h0);
        end

        // all 256 clear masks with mixed enables and control bits
        for (int m = 0; m < 256; m++) begin
            en = 8'(m) ^ 8'h5A;
            step(8'hFF, 1'b0, 32'h0);
            step(8'h00, 1'b1, {16'hC3A0 ^ 16'(m), en, 8'(m)});
            chk("R4 R5 mask sweep", rd, {16'hC3A0 ^ 16'(m), en, 8'(m)});
            chk("R7 mask sweep irq", {31'h0, irq}, {31'h0, |(8'(m) & en)});
        end

        // all-zero write
        step(8'hFF, 1'b1, 32'hFFFF_FFFF);
        chk("R7 all enabled irq", {31'h0, irq}, 32'h1);
        step(8'h00, 1'b1, 32'h0);
        chk("R8 zero write reg", rd, 32'h0);
        chk("R8 zero write irq", {31'h0, irq}, 32'h0);
        step(8'h00, 1'b0, 32'h0);
        chk("R4 hold without write", rd, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule